// File: doc/BRIEF.md
# Exception Entry Controller

This block decides, cycle by cycle, whether a small 32-bit processor core must enter an exception handler, and computes the architectural side effects of that entry. Four sources compete: a bus-fault strobe with its own fault vector, a software break strobe with the break vector, a non-maskable interrupt request, and a maskable interrupt request whose vector comes from an external interrupt controller. The two interrupts are only looked at on an instruction-boundary strobe and each has its own enable flag in the status word. The core supplies its current program counter and status word.

When an entry is taken, the block produces the following, all registered and valid for exactly one clock:
- an entry strobe
- the cause code and the handler vector number
- the new status word
- a single write to a return-address special register, given as an index and data

The core uses these to redirect fetch and update its registers. A second bus fault while the most recently accepted cause is still a bus fault cannot be handled. It drives a sticky fatal output instead, and the controller accepts nothing further until reset.

The controller is one state machine with three states:
- `ST_RUN`: idle, sampling requests.
- `ST_ENTER`: the cycle in which the entry outputs are valid.
- `ST_HALT`: the fatal lock.

Its transitions are:
- `RUN->ENTER` and `ENTER->ENTER`: a request is accepted.
- `RUN->RUN` and `ENTER->RUN`: nothing is accepted.
- `RUN->HALT` and `ENTER->HALT`: a recursive bus fault occurs.
- `HALT->HALT`: held until reset.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset every output is zero: no entry, cause 0, vector 0, status 0 (so the NMI enable bit 30 and the interrupt enable bit 4 read cleared), no return write, fatal low.
- R2: When several sources are accepted in the same cycle, the order of precedence is bus fault, then break, then non-maskable interrupt, then maskable interrupt.
- R3: A maskable interrupt is taken only when the boundary strobe is high and status bit 4 is set. It yields cause 4, the vector from the interrupt controller, and a write of the PC to return register index 10.
- R4: A non-maskable interrupt is taken only when the boundary strobe is high and status bit 30 is set. It yields cause 1, vector 0, the status word with bit 30 cleared, and a write of the PC to return register index 12.
- R5: A bus fault is taken regardless of boundary and flags. It yields cause 3, the supplied fault vector, and a write of the PC to return register index 10.
- R6: A break is taken regardless of boundary and flags. It yields cause 5, the supplied break vector, and a write of PC + 2 to return register index 10.
- R7: Entry outputs appear on the clock after the edge that sampled the request and last for exactly one cycle. Without a new accepted request they return to zero.
- R8: A bus fault arriving while the last accepted cause is bus fault raises fatal instead of an entry. Fatal stays high and no entry is produced until reset. Any other accepted cause in between clears this condition.
- R9: On every entry other than the non-maskable interrupt, the status output equals the input status word unchanged, including the Q bit 31.
- R10: Interrupt requests while the boundary strobe is low produce no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction boundary: interrupts may be sampled |
| irq_req_i | input | 1 | Maskable interrupt request |
| irq_vec_i | input | 8 | Vector from the interrupt controller |
| nmi_req_i | input | 1 | Non-maskable interrupt request |
| bus_fault_i | input | 1 | Bus-fault strobe |
| fault_vec_i | input | 8 | Vector accompanying the bus fault |
| brk_i | input | 1 | Software break strobe |
| brk_vec_i | input | 8 | Vector of the break |
| pc_i | input | 32 | Current program counter |
| status_i | input | 32 | Current status word |
| entry_o | output | 1 | Entry strobe, one cycle |
| cause_o | output | 3 | Cause code of the entry |
| vec_o | output | 8 | Handler vector number |
| status_o | output | 32 | Status word after entry |
| ret_we_o | output | 1 | Return-register write enable |
| ret_idx_o | output | 4 | Special register index written |
| ret_data_o | output | 32 | Value written to the return register |
| fatal_o | output | 1 | Sticky recursive-bus-fault error |

## Verification
Every result of this block lands one edge after the request is sampled: requests are driven just after a falling edge, and all entry fields are compared at the following falling edge. That falling edge comes after the single register stage has captured the result. One further falling edge later the bench confirms the strobe, cause and return write have dropped, which is the one-cycle rule. Fatal is checked one edge after the second bus fault and then re-checked over later cycles in which further requests must not produce an entry.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_NMI      = 3'd1,
        CAUSE_GURU     = 3'd2,
        CAUSE_BUSFAULT = 3'd3,
        CAUSE_IRQ      = 3'd4,
        CAUSE_BREAK    = 3'd5
    } cause_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ENTER = 2'd1,
        ST_HALT  = 2'd2
    } ctrl_state_e;

    localparam int unsigned IEN_BIT   = 4;
    localparam int unsigned MEN_BIT   = 30;
    localparam int unsigned QFLAG_BIT = 31;
    localparam int unsigned SREG_W    = 4;
    localparam logic [SREG_W-1:0] SREG_ERP = 4'd10;
    localparam logic [SREG_W-1:0] SREG_NRP = 4'd12;
    localparam logic [SREG_W-1:0] SREG_CCS = 4'd13;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic   bus_fault,
    input  logic   brk,
    input  logic   nmi_req,
    input  logic   irq_req,
    input  logic   boundary,
    input  logic   nmi_en,
    input  logic   irq_en,
    output cause_e cause
);
    logic nmi_ok;
    logic irq_ok;

    assign nmi_ok = nmi_req && boundary && nmi_en;
    assign irq_ok = irq_req && boundary && irq_en;

    always_comb begin
        if (bus_fault)   cause = CAUSE_BUSFAULT;
        else if (brk)    cause = CAUSE_BREAK;
        else if (nmi_ok) cause = CAUSE_NMI;
        else if (irq_ok) cause = CAUSE_IRQ;
        else             cause = CAUSE_NONE;
    end
endmodule

// File: rtl/exc_update.sv
module exc_update
    import exc_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned VEC_W = 8
) (
    input  cause_e                cause,
    input  logic [XLEN-1:0]       pc,
    input  logic [XLEN-1:0]       status,
    input  logic [VEC_W-1:0]      irq_vec,
    input  logic [VEC_W-1:0]      fault_vec,
    input  logic [VEC_W-1:0]      brk_vec,
    output logic [VEC_W-1:0]      vec,
    output logic [XLEN-1:0]       status_new,
    output logic [SREG_W-1:0]     ret_idx,
    output logic [XLEN-1:0]       ret_data
);
    localparam logic [XLEN-1:0] BRK_STEP = XLEN'(2);
    localparam logic [XLEN-1:0] MEN_MASK = XLEN'(1) << MEN_BIT;

    always_comb begin
        vec        = '0;
        status_new = status;
        ret_idx    = SREG_ERP;
        ret_data   = pc;
        unique case (cause)
            CAUSE_NMI: begin
                status_new = status & ~MEN_MASK;
                ret_idx    = SREG_NRP;
            end
            CAUSE_BUSFAULT: vec = fault_vec;
            CAUSE_BREAK: begin
                vec      = brk_vec;
                ret_data = pc + BRK_STEP;
            end
            CAUSE_IRQ: vec = irq_vec;
            default: begin
                status_new = status;
            end
        endcase
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned VEC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              irq_req_i,
    input  logic [VEC_W-1:0]  irq_vec_i,
    input  logic              nmi_req_i,
    input  logic              bus_fault_i,
    input  logic [VEC_W-1:0]  fault_vec_i,
    input  logic              brk_i,
    input  logic [VEC_W-1:0]  brk_vec_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   status_i,
    output logic              entry_o,
    output logic [2:0]        cause_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic [XLEN-1:0]   status_o,
    output logic              ret_we_o,
    output logic [SREG_W-1:0] ret_idx_o,
    output logic [XLEN-1:0]   ret_data_o,
    output logic              fatal_o
);
    ctrl_state_e state_q, state_d;
    cause_e      sel_cause;
    cause_e      last_cause_q;
    logic        recursive_fault;

    logic [VEC_W-1:0]  vec_d;
    logic [XLEN-1:0]   status_d;
    logic [SREG_W-1:0] ret_idx_d;
    logic [XLEN-1:0]   ret_data_d;

    exc_arbiter u_arb (
        .bus_fault (bus_fault_i),
        .brk       (brk_i),
        .nmi_req   (nmi_req_i),
        .irq_req   (irq_req_i),
        .boundary  (boundary_i),
        .nmi_en    (status_i[MEN_BIT]),
        .irq_en    (status_i[IEN_BIT]),
        .cause     (sel_cause)
    );

    exc_update #(.XLEN(XLEN), .VEC_W(VEC_W)) u_upd (
        .cause      (sel_cause),
        .pc         (pc_i),
        .status     (status_i),
        .irq_vec    (irq_vec_i),
        .fault_vec  (fault_vec_i),
        .brk_vec    (brk_vec_i),
        .vec        (vec_d),
        .status_new (status_d),
        .ret_idx    (ret_idx_d),
        .ret_data   (ret_data_d)
    );

    assign recursive_fault = bus_fault_i && (last_cause_q == CAUSE_BUSFAULT);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN, ST_ENTER: begin
                if (recursive_fault)               state_d = ST_HALT;
                else if (sel_cause != CAUSE_NONE)  state_d = ST_ENTER;
                else                               state_d = ST_RUN;
            end
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Registered outputs and recorded cause
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_o      <= '0;
            vec_o        <= '0;
            status_o     <= '0;
            ret_idx_o    <= '0;
            ret_data_o   <= '0;
            fatal_o      <= 1'b0;
            last_cause_q <= CAUSE_NONE;
        end else begin
            cause_o    <= '0;
            vec_o      <= '0;
            status_o   <= '0;
            ret_idx_o  <= '0;
            ret_data_o <= '0;
            if (state_d == ST_HALT) begin
                fatal_o <= 1'b1;
            end else if (state_d == ST_ENTER) begin
                cause_o      <= sel_cause;
                vec_o        <= vec_d;
                status_o     <= status_d;
                ret_idx_o    <= ret_idx_d;
                ret_data_o   <= ret_data_d;
                last_cause_q <= sel_cause;
            end
        end
    end

    assign entry_o  = (state_q == ST_ENTER);
    assign ret_we_o = entry_o;

    assert_entry_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |-> (cause_o != 3'd0));
    assert_nmi_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_o && cause_o == 3'(CAUSE_NMI)) |->
        (vec_o == '0 && !status_o[MEN_BIT] && ret_idx_o == SREG_NRP && ret_data_o == $past(pc_i)));
    assert_irq_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_o && cause_o == 3'(CAUSE_IRQ)) |-> $past(boundary_i && status_i[IEN_BIT]));
    assert_break_ret_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_o && cause_o == 3'(CAUSE_BREAK)) |-> (ret_data_o == $past(pc_i) + XLEN'(2)));
    assert_fatal_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_o |=> (fatal_o && !entry_o));
    assert_recursive_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_fault_i && last_cause_q == CAUSE_BUSFAULT) |=> fatal_o);
endmodule

// File: tb/test_exc_entry_ctrl.sv
`timescale 1ns/1ps
module test_exc_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        boundary_i, irq_req_i, nmi_req_i, bus_fault_i, brk_i;
    logic [7:0]  irq_vec_i, fault_vec_i, brk_vec_i;
    logic [31:0] pc_i, status_i;
    logic        entry_o, ret_we_o, fatal_o;
    logic [2:0]  cause_o;
    logic [7:0]  vec_o;
    logic [31:0] status_o, ret_data_o;
    logic [3:0]  ret_idx_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    exc_entry_ctrl i_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .irq_req_i(irq_req_i),
        .irq_vec_i(irq_vec_i), .nmi_req_i(nmi_req_i), .bus_fault_i(bus_fault_i),
        .fault_vec_i(fault_vec_i), .brk_i(brk_i), .brk_vec_i(brk_vec_i),
        .pc_i(pc_i), .status_i(status_i), .entry_o(entry_o), .cause_o(cause_o),
        .vec_o(vec_o), .status_o(status_o), .ret_we_o(ret_we_o),
        .ret_idx_o(ret_idx_o), .ret_data_o(ret_data_o), .fatal_o(fatal_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        boundary_i = 0; irq_req_i = 0; nmi_req_i = 0; bus_fault_i = 0; brk_i = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; idle_inputs();
        @(negedge clk); @(negedge clk);
        rst_n = 1;
    endtask

    task automatic expect_quiet(input string tag);
        chk({tag, " entry"}, 32'(entry_o), 0);
        chk({tag, " ret_we"}, 32'(ret_we_o), 0);
        chk({tag, " cause"}, 32'(cause_o), 0);
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; idle_inputs();
        irq_vec_i = 0; fault_vec_i = 0; brk_vec_i = 0; pc_i = 0; status_i = 0;
        do_reset();
        // R1: reset state
        chk("R1 entry", 32'(entry_o), 0);
        chk("R1 cause", 32'(cause_o), 0);
        chk("R1 vec", 32'(vec_o), 0);
        chk("R1 status", status_o, 0);
        chk("R1 ret_we", 32'(ret_we_o), 0);
        chk("R1 ret_idx", 32'(ret_idx_o), 0);
        chk("R1 ret_data", ret_data_o, 0);
        chk("R1 fatal", 32'(fatal_o), 0);

        // Sweep: R2 R3 R4 R5 R6 R7 R9 R10 over all request/flag combinations
        for (int k = 0; k < 128; k++) begin
            logic bf, bk, nm, iq, bd, ien, men;
            logic [2:0]  ec;
            logic [7:0]  ev;
            logic [3:0]  ei;
            logic [31:0] ed, es, st;
            bf = k[0]; bk = k[1]; nm = k[2]; iq = k[3]; bd = k[4]; ien = k[5]; men = k[6];
            do_reset();
            st = 32'h8000_0000 | (32'(k) << 8) | (32'(ien) << 4) | (32'(men) << 30) | 32'h3;
            pc_i = 32'h0001_0000 + 32'(k) * 4;
            status_i = st;
            irq_vec_i = 8'(k + 8'h40); fault_vec_i = 8'(k + 8'h80); brk_vec_i = 8'(k + 8'h20);
            // expected, by precedence R2
            ec = 0; ev = 0; ei = 0; ed = 0; es = 0;
            if (bf) begin ec = 3; ev = fault_vec_i; ei = 10; ed = pc_i; es = st; end
            else if (bk) begin ec = 5; ev = brk_vec_i; ei = 10; ed = pc_i + 2; es = st; end
            else if (nm && bd && men) begin ec = 1; ev = 0; ei = 12; ed = pc_i; es = st & ~32'h4000_0000; end
            else if (iq && bd && ien) begin ec = 4; ev = irq_vec_i; ei = 10; ed = pc_i; es = st; end
            bus_fault_i = bf; brk_i = bk; nmi_req_i = nm; irq_req_i = iq; boundary_i = bd;
            @(negedge clk);
            idle_inputs();
            chk("R2/R10 entry", 32'(entry_o), 32'(ec != 0));
            chk("R2 cause", 32'(cause_o), 32'(ec));
            chk("R3/R5/R6 vec", 32'(vec_o), 32'(ev));
            chk("R4/R9 status", status_o, es);
            chk("R3/R4/R5 ret_we", 32'(ret_we_o), 32'(ec != 0));
            chk("R3/R4/R5 ret_idx", 32'(ret_idx_o), 32'(ei));
            chk("R6 ret_data", ret_data_o, ed);
            @(negedge clk);
            expect_quiet("R7 one-cycle");
        end

        // R8: recursive bus fault
        do_reset();
        pc_i = 32'h100; status_i = 32'h4000_0010; fault_vec_i = 8'h11;
        bus_fault_i = 1; @(negedge clk); bus_fault_i = 0;
        chk("R8 first fault cause", 32'(cause_o), 3);
        chk("R8 first fault no fatal", 32'(fatal_o), 0);
        @(negedge clk);
        bus_fault_i = 1; @(negedge clk); bus_fault_i = 0;
        chk("R8 fatal raised", 32'(fatal_o), 1);
        chk("R8 no entry on fatal", 32'(entry_o), 0);
        boundary_i = 1; irq_req_i = 1; nmi_req_i = 1; brk_i = 1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk("R8 halted fatal", 32'(fatal_o), 1);
            chk("R8 halted entry", 32'(entry_o), 0);
        end
        idle_inputs();

        // R8: intervening break clears the recursive condition
        do_reset();
        chk("R8 reset clears fatal", 32'(fatal_o), 0);
        bus_fault_i = 1; @(negedge clk); bus_fault_i = 0;
        brk_i = 1; @(negedge clk); brk_i = 0;
        chk("R8 break between", 32'(cause_o), 5);
        bus_fault_i = 1; @(negedge clk); bus_fault_i = 0;
        chk("R8 fault after break entry", 32'(entry_o), 1);
        chk("R8 fault after break no fatal", 32'(fatal_o), 0);

        // R7: back-to-back entries on consecutive cycles
        do_reset();
        status_i = 32'h0000_0010; boundary_i = 1; irq_req_i = 1; irq_vec_i = 8'h55;
        @(negedge clk);
        chk("R7 b2b first", 32'(entry_o), 1);
        @(negedge clk);
        chk("R7 b2b second", 32'(entry_o), 1);
        chk("R3 b2b vec", 32'(vec_o), 32'h55);
        idle_inputs();
        @(negedge clk);
        expect_quiet("R7 after b2b");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule